// File: doc/BRIEF.md
# Pixel Clock Synthesizer Word Calculator

This block turns a requested pixel-clock period, given in picoseconds, into the 13-bit programming word for a serially loaded frequency synthesizer. It first computes the requested frequency in units of 0.01 MHz. It then picks a power-of-two output divider that lifts the oscillator into its legal band. Next it derives the rounded feedback count from a fixed reference frequency and a fixed reference divider. Finally it packs the count, a divider code and a pair of fixed stop bits into one word.

A single-cycle `start_i` pulse launches a calculation. One shared restoring divider is used three times in sequence: for the frequency, for the feedback ratio and for the rounding step. The results appear together with a one-cycle `done_o` pulse. Requests that are out of range complete with `err_o` set and do not produce a usable word. Shifting the word into the synthesizer is left to a separate block.

Top module: `pclk_word_calc`

## Requirements
- R1: After reset, `done_o` = 0, `err_o` = 0, `word_o` = 0 and `pdiv_o` = 1.
- R2: A `start_i` pulse seen while the block is idle, with a non-zero period, starts a calculation. `done_o` is then high for exactly one cycle. The frequency used is f = 100000000 / period, with integer division.
- R3: A period of zero seen with `start_i` while idle gives `done_o` in the next cycle, with `err_o` = 1, `word_o` = 0 and `pdiv_o` = 1.
- R4: If f > 15938, the result has `err_o` = 1, `word_o` = 0 and `pdiv_o` = 1.
- R5: If f < 1000, the result has `err_o` = 1, `word_o` = 0 and `pdiv_o` = 1.
- R6: For a valid f, the output divider d starts at 1, and f and d are both doubled while f < 8000. `pdiv_o` reports d, which is 1, 2, 4 or 8, as a binary value.
- R7: The feedback count is n = ((46 · fs · 1000) / 1432 + 500) / 1000, where fs is the doubled frequency and every division truncates.
- R8: The word has this layout. Bits [8:0] hold n − 257. Bits [10:9] hold the divider code: d=1 gives 3, d=2 gives 2, d=4 gives 1 and d=8 gives 0. Bits [12:11] are always 2'b11.
- R9: `start_i` is ignored whenever the block is not idle, including the cycle in which `done_o` is high. Between two done pulses, `word_o`, `err_o` and `pdiv_o` hold their values.
- R10: The edge frequencies f = 15938 and f = 1000 are both accepted, with `err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle launch pulse |
| period_i | input | 32 | Requested pixel period in picoseconds |
| done_o | output | 1 | One-cycle result-valid pulse |
| err_o | output | 1 | Request out of range or zero period |
| word_o | output | 13 | Packed synthesizer programming word |
| pdiv_o | output | 4 | Selected output divider (1, 2, 4 or 8) |

## Verification
The block's completion and its acceptance of a new request can fall in the same cycle. That happens when `start_i` arrives exactly while `done_o` is high. The bench provokes this by raising `start_i` on the cycle where it observes `done_o`. It then judges the result by seeing no further done pulse over a window longer than a full calculation, followed by a later start that is accepted normally. In the same way, a start injected mid-calculation must leave the result of the first request unchanged.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

  localparam int unsigned FREQ_NUM    = 100_000_000;
  localparam int unsigned F_MAX       = 15938;
  localparam int unsigned F_MIN       = 1000;
  localparam int unsigned VCO_FLOOR   = 8000;
  localparam int unsigned REF_DIV     = 46;
  localparam int unsigned REF_FREQ    = 1432;
  localparam int unsigned ROUND_SCALE = 1000;
  localparam int unsigned N_OFFSET    = 257;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_CNT,
    ST_RND,
    ST_FIN
  } calc_st_e;

  // smallest power-of-two divider that lifts f to the VCO floor
  function automatic logic [3:0] pick_pdiv(input int unsigned f);
    if (f >= VCO_FLOOR)          return 4'd1;
    else if (f >= VCO_FLOOR / 2) return 4'd2;
    else if (f >= VCO_FLOOR / 4) return 4'd4;
    return 4'd8;
  endfunction

  function automatic logic [1:0] pdiv_code(input logic [3:0] pd);
    case (pd)
      4'd1:    return 2'd3;
      4'd2:    return 2'd2;
      4'd4:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic int unsigned scale_freq(input int unsigned f, input logic [3:0] pd);
    case (pd)
      4'd1:    return f;
      4'd2:    return f << 1;
      4'd4:    return f << 2;
      default: return f << 3;
    endcase
  endfunction

  function automatic logic out_of_range(input int unsigned f);
    return (f > F_MAX) || (f < F_MIN);
  endfunction

endpackage

// File: rtl/pclk_seq_div.sv
module pclk_seq_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] q_o,
  output logic         fin_o,
  output logic         busy_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, fin_q;
  logic [W:0]    trial_w, diff_w;
  logic          take_w;

  assign trial_w = {rem_q, quo_q[W-1]};
  assign diff_w  = trial_w - {1'b0, den_q};
  assign take_w  = trial_w >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go_i) begin
        quo_q  <= a_i;
        rem_q  <= '0;
        den_q  <= b_i;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q <= {quo_q[W-2:0], take_w};
        rem_q <= take_w ? diff_w[W-1:0] : trial_w[W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign q_o    = quo_q;
  assign fin_o  = fin_q;
  assign busy_o = busy_q;

  // R2: each pass ends in a single-cycle completion
  a_r2_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
  // R2: completion only follows a busy pass
  a_r2_fin_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_q) |-> $past(busy_q));
  // R9: the sequencer never relaunches a pass in flight
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_q);

endmodule

// File: rtl/pclk_word_pack.sv
module pclk_word_pack #(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 13
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic [3:0]        pdiv_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int FIELD_W = WORD_W - 4;

  logic [CNT_W-1:0]   low_w;
  logic [FIELD_W-1:0] field_w;

  assign low_w   = count_i - CNT_W'(pclk_pkg::N_OFFSET);
  assign field_w = low_w[FIELD_W-1:0];
  assign word_o  = {2'b11, pclk_pkg::pdiv_code(pdiv_i), field_w};

endmodule

// File: rtl/pclk_word_calc.sv
module pclk_word_calc #(
  parameter int PERIOD_W = 32,
  parameter int WORD_W   = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                done_o,
  output logic                err_o,
  output logic [WORD_W-1:0]   word_o,
  output logic [3:0]          pdiv_o
);
  import pclk_pkg::*;

  localparam int CNT_W = 16;

  calc_st_e            st_q;
  logic [PERIOD_W-1:0] div_a, div_b, div_q;
  logic                div_go, div_fin, div_busy;
  logic [3:0]          pd_q, pdiv_q;
  logic [WORD_W-1:0]   word_q, packed_w;
  logic                err_q;

  // named internal events
  logic       idle_w, fin_w, freq_bad_w, zero_req_w;
  logic [3:0] pd_pick_w;

  assign idle_w     = (st_q == ST_IDLE);
  assign fin_w      = (st_q == ST_FIN);
  assign zero_req_w = idle_w && start_i && (period_i == '0);
  assign freq_bad_w = out_of_range(32'(div_q));
  assign pd_pick_w  = pick_pdiv(32'(div_q));

  pclk_seq_div #(.W(PERIOD_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (div_go),
    .a_i    (div_a),
    .b_i    (div_b),
    .q_o    (div_q),
    .fin_o  (div_fin),
    .busy_o (div_busy)
  );

  pclk_word_pack #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_pack (
    .count_i (div_q[CNT_W-1:0]),
    .pdiv_i  (pd_q),
    .word_o  (packed_w)
  );

  always_comb begin
    div_go = 1'b0;
    div_a  = '0;
    div_b  = '0;
    case (st_q)
      ST_IDLE: if (start_i && period_i != '0) begin
        div_go = 1'b1;
        div_a  = PERIOD_W'(FREQ_NUM);
        div_b  = period_i;
      end
      ST_FREQ: if (div_fin && !freq_bad_w) begin
        div_go = 1'b1;
        div_a  = PERIOD_W'(REF_DIV * ROUND_SCALE * scale_freq(32'(div_q), pd_pick_w));
        div_b  = PERIOD_W'(REF_FREQ);
      end
      ST_CNT: if (div_fin) begin
        div_go = 1'b1;
        div_a  = div_q + PERIOD_W'(ROUND_SCALE / 2);
        div_b  = PERIOD_W'(ROUND_SCALE);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      word_q <= '0;
      err_q  <= 1'b0;
      pdiv_q <= 4'd1;
      pd_q   <= 4'd1;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          if (period_i == '0) begin
            err_q  <= 1'b1;
            word_q <= '0;
            pdiv_q <= 4'd1;
            st_q   <= ST_FIN;
          end else begin
            st_q <= ST_FREQ;
          end
        end
        ST_FREQ: if (div_fin) begin
          if (freq_bad_w) begin
            err_q  <= 1'b1;
            word_q <= '0;
            pdiv_q <= 4'd1;
            st_q   <= ST_FIN;
          end else begin
            pd_q <= pd_pick_w;
            st_q <= ST_CNT;
          end
        end
        ST_CNT: if (div_fin) st_q <= ST_RND;
        ST_RND: if (div_fin) begin
          word_q <= packed_w;
          pdiv_q <= pd_q;
          err_q  <= 1'b0;
          st_q   <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = fin_w;
  assign err_o  = err_q;
  assign word_o = word_q;
  assign pdiv_o = pdiv_q;

  // R2: done is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R3: zero period completes at once with an error
  a_r3_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req_w |=> (done_o && err_o));
  // R4 / R5: an error result carries an all-zero word
  a_r4_err_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (word_o == '0));
  // R6: a valid result reports exactly one divider bit
  a_r6_pdiv_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> ($countones(pdiv_o) == 1));
  // R8: stop bits are always present in a valid word
  a_r8_stop_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (word_o[WORD_W-1 -: 2] == 2'b11));
  // R9: results hold between done pulses
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(word_o) && $stable(err_o) && $stable(pdiv_o)));

endmodule

// File: tb/pclk_word_calc_tb.sv
module pclk_word_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] period_i = '0;
  logic        done_o, err_o;
  logic [12:0] word_o;
  logic [3:0]  pdiv_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  pclk_word_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .period_i(period_i),
    .done_o(done_o), .err_o(err_o), .word_o(word_o), .pdiv_o(pdiv_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung (actual cyc=%0d expected <150000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected result restated from the requirements
  function automatic void model(input longint unsigned p, output logic [12:0] w,
                                output logic [3:0] pd, output bit e);
    longint unsigned f, fs, d, n, code;
    w = '0; pd = 4'd1; e = 1'b1;
    if (p == 0) return;
    f = 64'd100000000 / p;
    if (f > 15938 || f < 1000) return;
    fs = f; d = 1;
    while (fs < 8000) begin fs = fs * 2; d = d * 2; end
    n = ((46 * fs * 1000) / 1432 + 500) / 1000;
    code = (d == 1) ? 3 : (d == 2) ? 2 : (d == 4) ? 1 : 0;
    e  = 1'b0;
    pd = 4'(d);
    w  = 13'((64'h3 << 11) | (code << 9) | ((n - 257) & 64'h1ff));
  endfunction

  task automatic pulse_start(input logic [31:0] p);
    @(negedge clk);
    start_i  = 1'b1;
    period_i = p;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done_o) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, req, 0, 1);
  endtask

  task automatic check_result(input logic [31:0] p, input string req);
    logic [12:0] ew; logic [3:0] ep; bit ee;
    model(p, ew, ep, ee);
    chk(err_o == ee, {req, " err"}, err_o, ee);
    chk(word_o == ew, {req, " word"}, word_o, ew);
    chk(pdiv_o == ep, {req, " pdiv"}, pdiv_o, ep);
  endtask

  task automatic t_calc(input logic [31:0] p, input string req);
    bit seen;
    pulse_start(p);
    wait_done(req, seen);
    check_result(p, req);
    @(negedge clk);
    chk(!done_o, "R2 done one cycle", done_o, 0);
  endtask

  task automatic t_reset();
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(err_o == 1'b0, "R1 err", err_o, 0);
    chk(word_o == '0, "R1 word", word_o, 0);
    chk(pdiv_o == 4'd1, "R1 pdiv", pdiv_o, 1);
  endtask

  task automatic t_zero();
    pulse_start(32'd0);
    chk(done_o == 1'b1, "R3 immediate done", done_o, 1);
    check_result(32'd0, "R3");
    @(negedge clk);
  endtask

  task automatic t_busy_start();
    bit seen;
    pulse_start(32'd20000);
    repeat (10) @(negedge clk);
    start_i = 1'b1; period_i = 32'd10000;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R9 busy", seen);
    check_result(32'd20000, "R9 busy start ignored");
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
    chk(!seen, "R9 no extra done after busy start", seen, 0);
  endtask

  task automatic t_done_cycle_start();
    bit seen;
    logic [12:0] w0;
    pulse_start(32'd39722);
    wait_done("R9 done-cycle", seen);
    w0 = word_o;
    start_i = 1'b1; period_i = 32'd6273;
    @(negedge clk);
    start_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done_o) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R9 start in done cycle ignored", seen, 0);
    chk(word_o == w0, "R9 word held", word_o, w0);
    t_calc(32'd6273, "R4 accepted after done-cycle start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_calc(32'd10000, "R2 R7 R8 f=10000 d=1");
    t_calc(32'd20000, "R6 R8 f=5000 d=2");
    t_calc(32'd39722, "R6 R7 f=2517 d=4");
    t_calc(32'd70000, "R6 R8 f=1428 d=8");
    t_calc(32'd12500, "R7 f=8000 edge of VCO floor");
    t_zero();
    t_calc(32'd6273, "R4 f=15941 too high");
    t_calc(32'd1, "R4 huge frequency");
    t_calc(32'd100001, "R5 f=999 too low");
    t_calc(32'hFFFF_FFFF, "R5 f=0");
    t_calc(32'd6274, "R10 f=15938 upper edge");
    t_calc(32'd100000, "R10 f=1000 lower edge");
    t_busy_start();
    t_done_cycle_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule